// File: doc/BRIEF.md
# Interpolating quarter-wave sine generator

This block turns a phase word into a signed sine sample. It is the phase-to-amplitude stage of a numerically controlled oscillator. A phase accumulator outside the block feeds it one phase code per cycle, marked by a valid strobe. The block returns the matching amplitude three clock cycles later, with a valid strobe delayed by the same amount.

Only one quarter of a period is stored. A 256-entry table holds the magnitude. A narrow second table holds the step from each entry to the next. The low phase bits scale that step, which gives one linear interpolation between neighbouring samples. The two high phase bits pick the quadrant. In the second and fourth quadrants the block walks the quarter backwards. In the lower half of the period it negates the result. Both tables are constants computed during elaboration.

Top module: `qsin_gen`

## Requirements
- R1: The phase word is 18 bits. Bits 17:16 are the quadrant, bits 15:8 are the table index and bits 7:0 are the residue. In quadrant 0 the output is amp[index] + ((step[index] * residue) >> 8), so phase 0 gives 0.
- R2: amp[k] = round(sin(k*pi/512) * 262143) for k = 0..255. The step is step[k] = amp[k+1] - amp[k], with amp[256] taken as 262143. Every step fits in 11 unsigned bits, and no step is larger than 1609.
- R3: The product of step and residue is shifted right by 8 with truncation. Phase 0x00001 gives 6, and phase 0x00080 gives 804.
- R4: When quadrant bit 16 is set, the lower 16 phase bits are inverted before the index and residue are taken. Phase 0x10000 gives 262142.
- R5: When quadrant bit 17 is set, the magnitude is negated. The output is a 19-bit two's-complement value: phase 0x20080 gives -804, and phase 0x30000 gives -262142.
- R6: The output magnitude never reaches full scale: -262142 <= output <= 262142 for every phase.
- R7: For every phase p, the output is within 10 LSB of round(sin(2*pi*p/262144) * 262143).
- R8: The output valid strobe equals the input valid strobe from exactly 3 clock cycles earlier. The latency is fixed.
- R9: While reset (synchronous, active high) is applied, the output and the output valid are 0 from the first clock edge on.
- R10: Whenever the ideal value is more than 10 LSB away from zero, the output has the same sign as the ideal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ph_vld_i | input | 1 | Phase code valid |
| ph_i | input | 18 | Phase code: quadrant, index, residue |
| smp_vld_o | output | 1 | Sample valid, 3 cycles after ph_vld_i |
| smp_o | output | 19 | Signed sine sample |

## Verification
The bench first drives hand-computed phase codes. Codes with a zero residue, a small residue and a mid residue separate the table read from the truncated interpolation term. Codes at the quadrant edges (0x10000, 0x20000, 0x30000, 0x3FFFF) expose a missing mirror, a wrong negation or a mirror that is off by one index. It then sweeps the whole phase circle in steps of five, with valid gaps mixed in, and compares each sample with a real-valued sine. The sweep catches table, scaling and sign errors anywhere on the wave, and the gaps show up a wrong valid delay. A reset applied in the middle of a stream confirms that the pipeline clears.

// File: rtl/qsin_pkg.sv
package qsin_pkg;

   localparam real QS_PI = 3.14159265358979323846;

   // Quarter-wave magnitude for table slot k; slot 2**idx_w is the full-scale end point.
   function automatic int qs_amp(input int k, input int idx_w, input int amp_w);
      real fs;
      real ang;
      fs = (2.0 ** amp_w) - 1.0;
      if (k >= (1 << idx_w)) return $rtoi(fs);
      ang = (QS_PI * k) / (2.0 * (1 << idx_w));
      return $rtoi($sin(ang) * fs + 0.5);
   endfunction

   // Rise from slot k to slot k+1.
   function automatic int qs_step(input int k, input int idx_w, input int amp_w);
      return qs_amp(k + 1, idx_w, amp_w) - qs_amp(k, idx_w, amp_w);
   endfunction

endpackage

// File: rtl/qsin_rom.sv
module qsin_rom
   import qsin_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int RES_W = 8,
   parameter int AMP_W = 18,
   parameter int SLP_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             vld_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [RES_W-1:0] res_i,
   input  logic             neg_i,
   output logic             vld_o,
   output logic [AMP_W-1:0] amp_o,
   output logic [SLP_W-1:0] slp_o,
   output logic [RES_W-1:0] res_o,
   output logic             neg_o
);

   localparam int DEPTH = 1 << IDX_W;
   localparam logic [AMP_W:0] FULL = {1'b0, {AMP_W{1'b1}}};

   logic [AMP_W-1:0] amp_tab [DEPTH];
   logic [SLP_W-1:0] slp_tab [DEPTH];

   // Build both constant tables and check that each step fits its field.
   for (genvar k = 0; k < DEPTH; k++) begin : g_tab
      localparam int A = qs_amp(k, IDX_W, AMP_W);
      localparam int S = qs_step(k, IDX_W, AMP_W);
      if (S < 0 || S >= (1 << SLP_W)) begin : g_bad_step
         $error("qsin_rom: step %0d at slot %0d does not fit", S, k);
      end
      assign amp_tab[k] = AMP_W'(A);
      assign slp_tab[k] = SLP_W'(S);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
         amp_o <= '0;
         slp_o <= '0;
         res_o <= '0;
         neg_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         amp_o <= amp_tab[idx_i];
         slp_o <= slp_tab[idx_i];
         res_o <= res_i;
         neg_o <= neg_i;
      end
   end

   // R2
   slope_bound_chk: assert property (@(posedge clk) disable iff (rst)
      vld_o |-> ({1'b0, amp_o} + (AMP_W+1)'(slp_o)) <= FULL);

   // R2
   slope_max_chk: assert property (@(posedge clk) disable iff (rst)
      vld_o |-> slp_o <= SLP_W'(1609));

endmodule

// File: rtl/qsin_interp.sv
module qsin_interp #(
   parameter int RES_W = 8,
   parameter int AMP_W = 18,
   parameter int SLP_W = 11,
   localparam int OUT_W = AMP_W + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    vld_i,
   input  logic [AMP_W-1:0]        amp_i,
   input  logic [SLP_W-1:0]        slp_i,
   input  logic [RES_W-1:0]        res_i,
   input  logic                    neg_i,
   output logic                    vld_o,
   output logic signed [OUT_W-1:0] smp_o
);

   localparam int PRD_W = SLP_W + RES_W;
   localparam logic [AMP_W:0] FULL = {1'b0, {AMP_W{1'b1}}};

   // Multiply stage
   logic [PRD_W-1:0] prod;
   logic [SLP_W-1:0] frac_q;
   logic [AMP_W-1:0] amp_q;
   logic             neg_q;
   logic             vld_q;

   assign prod = PRD_W'(slp_i) * PRD_W'(res_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         frac_q <= '0;
         amp_q  <= '0;
         neg_q  <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         frac_q <= prod[PRD_W-1:RES_W];
         amp_q  <= amp_i;
         neg_q  <= neg_i;
         vld_q  <= vld_i;
      end
   end

   // Add and sign stage
   logic [AMP_W:0]          mag;
   logic signed [OUT_W-1:0] smp_d;

   assign mag   = {1'b0, amp_q} + (AMP_W+1)'(frac_q);
   assign smp_d = neg_q ? -$signed(mag) : $signed(mag);

   always_ff @(posedge clk) begin
      if (rst) begin
         smp_o <= '0;
         vld_o <= 1'b0;
      end else begin
         smp_o <= smp_d;
         vld_o <= vld_q;
      end
   end

   // R6
   no_fullscale_chk: assert property (@(posedge clk) disable iff (rst)
      vld_q |-> mag < FULL);

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (!vld_o && smp_o == '0));

endmodule

// File: rtl/qsin_gen.sv
module qsin_gen #(
   parameter int PH_W  = 18,
   parameter int IDX_W = 8,
   parameter int AMP_W = 18,
   parameter int SLP_W = 11
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ph_vld_i,
   input  logic [PH_W-1:0]         ph_i,
   output logic                    smp_vld_o,
   output logic signed [AMP_W:0]   smp_o
);

   localparam int RES_W = PH_W - 2 - IDX_W;
   localparam int LOW_W = PH_W - 2;

   if (RES_W < 1) begin : g_bad_split
      $error("qsin_gen: phase too narrow for index plus residue");
   end
   if (AMP_W < 4 || AMP_W > 30) begin : g_bad_amp
      $error("qsin_gen: amplitude width out of range");
   end
   if (SLP_W >= AMP_W) begin : g_bad_slope
      $error("qsin_gen: slope field must be narrower than amplitude");
   end

   // Phase decode: quadrant picks mirroring and sign
   logic [1:0]       quad;
   logic [LOW_W-1:0] low;
   logic [LOW_W-1:0] walk;
   logic [IDX_W-1:0] idx;
   logic [RES_W-1:0] res;

   assign quad = ph_i[PH_W-1 -: 2];
   assign low  = ph_i[LOW_W-1:0];
   assign walk = quad[0] ? ~low : low;
   assign idx  = walk[LOW_W-1 -: IDX_W];
   assign res  = walk[RES_W-1:0];

   logic             s1_vld;
   logic [AMP_W-1:0] s1_amp;
   logic [SLP_W-1:0] s1_slp;
   logic [RES_W-1:0] s1_res;
   logic             s1_neg;

   qsin_rom #(
      .IDX_W (IDX_W),
      .RES_W (RES_W),
      .AMP_W (AMP_W),
      .SLP_W (SLP_W)
   ) u_rom (
      .clk   (clk),
      .rst   (rst),
      .vld_i (ph_vld_i),
      .idx_i (idx),
      .res_i (res),
      .neg_i (quad[1]),
      .vld_o (s1_vld),
      .amp_o (s1_amp),
      .slp_o (s1_slp),
      .res_o (s1_res),
      .neg_o (s1_neg)
   );

   qsin_interp #(
      .RES_W (RES_W),
      .AMP_W (AMP_W),
      .SLP_W (SLP_W)
   ) u_interp (
      .clk   (clk),
      .rst   (rst),
      .vld_i (s1_vld),
      .amp_i (s1_amp),
      .slp_i (s1_slp),
      .res_i (s1_res),
      .neg_i (s1_neg),
      .vld_o (smp_vld_o),
      .smp_o (smp_o)
   );

   // Cycles since reset, saturating at the pipeline depth, for the latency checks
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst)               warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // R8
   valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3) |-> (smp_vld_o == $past(ph_vld_i, 3)));

   // R5
   sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3 && smp_vld_o && smp_o != '0) |-> (smp_o[AMP_W] == $past(ph_i[PH_W-1], 3)));

   // R6
   out_range_chk: assert property (@(posedge clk) disable iff (rst)
      smp_vld_o |-> (smp_o != {1'b1, {AMP_W{1'b0}}} + 1'b1) && (smp_o != {1'b0, {AMP_W{1'b1}}}));

endmodule

// File: tb/qsin_gen_bench.sv
module qsin_gen_bench;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic               rst;
   logic               vi;
   logic [17:0]        ph;
   logic               vo;
   logic signed [18:0] so;

   int n_chk  = 0;
   int n_fail = 0;

   qsin_gen u_qsin_gen (
      .clk       (clk),
      .rst       (rst),
      .ph_vld_i  (vi),
      .ph_i      (ph),
      .smp_vld_o (vo),
      .smp_o     (so)
   );

   typedef struct packed {
      logic [17:0] ph;
      int          ex;
      int          tol;
   } vec_t;

   // Directed vectors: phase, expected sample, tolerance
   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{18'h00000,       0,  0},   // R1 zero phase
      '{18'h00001,       6,  0},   // R3 small residue, truncated
      '{18'h00080,     804,  0},   // R3 mid residue
      '{18'h10000,  262142,  0},   // R4 mirrored peak
      '{18'h20000,       0,  0},   // R5 negated zero
      '{18'h20080,    -804,  0},   // R5 negated interpolation
      '{18'h30000, -262142,  0},   // R5 negated mirrored peak
      '{18'h08000,  185363, 10},   // R7 pi/4
      '{18'h18000,  185363, 10},   // R4 3pi/4
      '{18'h28000, -185363, 10},   // R5 5pi/4
      '{18'h38000, -185363, 10},   // R5 7pi/4
      '{18'h3FFFF,      -6, 10}    // R7 last code before wrap
   };

   // History of the last three drives
   logic hv [3];
   int   hex [3];
   int   htol [3];
   bit   hsw [3];

   function automatic int ref_sin(input logic [17:0] p);
      real a;
      a = 2.0 * 3.14159265358979323846 * real'(p) / 262144.0;
      return int'($sin(a) * 262143.0);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic clear_hist();
      for (int i = 0; i < 3; i++) begin
         hv[i] = 1'b0; hex[i] = 0; htol[i] = 0; hsw[i] = 1'b0;
      end
   endtask

   // Called at a falling edge: check the output for the drive of three cycles ago, then drive.
   task automatic drive(input bit v, input logic [17:0] p, input int ex, input int tol, input bit sw);
      int d;
      chk(vo == hv[2], "R8 valid latency", int'(vo), int'(hv[2]));
      if (hv[2]) begin
         d = int'(so) - hex[2];
         if (d < 0) d = -d;
         chk(d <= htol[2], hsw[2] ? "R7 accuracy" : "R1 R3 R4 R5 directed value", int'(so), hex[2]);
         if (hsw[2]) begin
            chk(so <= 262142 && so >= -262142, "R6 below full scale", int'(so), hex[2]);
            if (hex[2] > 10)  chk(so > 0, "R10 sign", int'(so), hex[2]);
            if (hex[2] < -10) chk(so < 0, "R10 sign", int'(so), hex[2]);
         end
      end
      for (int i = 2; i > 0; i--) begin
         hv[i] = hv[i-1]; hex[i] = hex[i-1]; htol[i] = htol[i-1]; hsw[i] = hsw[i-1];
      end
      hv[0] = v; hex[0] = ex; htol[0] = tol; hsw[0] = sw;
      vi = v;
      ph = p;
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst = 1'b1;
      vi  = 1'b0;
      ph  = '0;
      clear_hist();
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(vo == 1'b0, "R9 reset valid", int'(vo), 0);
      chk(so == '0, "R9 reset sample", int'(so), 0);
      rst = 1'b0;

      // Directed vectors, back to back
      for (int i = 0; i < NV; i++) drive(1'b1, VECS[i].ph, VECS[i].ex, VECS[i].tol, 1'b0);
      // A lone valid pulse after idle cycles (R8)
      for (int i = 0; i < 4; i++) drive(1'b0, 18'h0, 0, 0, 1'b0);
      drive(1'b1, 18'h00080, 804, 0, 1'b0);
      for (int i = 0; i < 4; i++) drive(1'b0, 18'h12345, 0, 0, 1'b0);

      // Sweep of the whole circle, every 16th slot idle
      for (int p = 0; p < 262144; p += 5) begin
         if ((p / 5) % 16 == 15) drive(1'b0, 18'(p), 0, 0, 1'b0);
         else                    drive(1'b1, 18'(p), ref_sin(18'(p)), 10, 1'b1);
      end
      for (int i = 0; i < 3; i++) drive(1'b0, 18'h0, 0, 0, 1'b0);

      // Reset in the middle of a stream (R9)
      for (int i = 0; i < 3; i++) drive(1'b1, 18'h10000, 262142, 0, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      chk(vo == 1'b0, "R9 mid-stream reset valid", int'(vo), 0);
      chk(so == '0, "R9 mid-stream reset sample", int'(so), 0);
      rst = 1'b0;
      vi  = 1'b0;
      clear_hist();
      for (int i = 0; i < 4; i++) drive(1'b0, 18'h0, 0, 0, 1'b0);

      summary();
      $finish;
   end

endmodule